// File: doc/BRIEF.md
# Framed Serial Sample Receiver for a Transmit DAC

This block takes transmit samples that arrive one bit at a time and hands each finished sample to the input register of a digital-to-analog converter. The serial clock, the data line and the active-low frame marker are sampled on a faster system clock. They must already be synchronous to that clock. A falling edge on the frame marker opens a word. The block then takes one data bit on each rising edge of the serial clock, most significant bit first.

A word is sixteen bits long. The first fourteen bits form the sample and the last two are dropped. After the sixteenth bit the sample moves into a holding register, and a load strobe is raised for one system clock. The holding register keeps that value until the next complete word arrives.

Two framing faults set a sticky error flag, and the word in progress is dropped without a load. The first fault is a frame marker that falls again before the current word is complete. The second is a marker pulse too short to still be low at the first serial clock rise of its word. Only reset clears the flag.

Top module: `dac_word_rx`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `sample` is 0, `load` is 0 and `frame_err` is 0.
- R2: A word opens on the system clock in which `frame_n` is seen low after being seen high. Each later system clock in which `sclk` is seen high after being seen low captures `sdata`, most significant bit first. The first fourteen captured bits become `sample`: bit 13 is the first bit and bit 0 is the fourteenth.
- R3: The fifteenth and sixteenth captured bits of a word have no effect on `sample`.
- R4: `load` is high for exactly one system clock. That clock is the one that follows the clock in which the sixteenth rise is seen. `sample` changes only in that same clock and holds its value at all other times.
- R5: If `frame_n` falls again before sixteen bits of the open word are captured, that word produces no load and `frame_err` is set. The new fall opens a fresh word, and that word is received normally.
- R6: If `frame_n` is seen high at the first `sclk` rise after it fell, the pulse is too short. `frame_err` is set, and no bit of that frame is ever loaded.
- R7: Once `frame_err` is set, it stays set through later good words until reset.
- R8: `sclk` rises seen while no word is open shift nothing and cause no load. This covers rises before the first fall, rises after the sixteenth bit, and rises after a short pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial bit clock, synchronous to `clk` and slower than it |
| sdata | input | 1 | Serial data, most significant bit first |
| frame_n | input | 1 | Active-low frame marker; its falling edge opens a word |
| sample | output | 14 | Held sample from the last complete word |
| load | output | 1 | One-cycle strobe marking a new `sample` |
| frame_err | output | 1 | Sticky framing error flag |

## Verification
Every result is registered one stage behind the edge detectors. `load`, the new `sample` and a newly set `frame_err` all appear in the `clk` cycle right after the edge in which the deciding `sclk` rise or `frame_n` fall is first seen high or low. The bench drives inputs on falling `clk` edges. In the directed words it reads `load` and `sample` at the very next falling edge after the sixteenth `sclk` high. It checks one edge later that `load` has dropped again. For stretched and random words, a falling-edge monitor counts strobes and keeps the last loaded value. The bench reads these only after a further idle edge, so that its reads never share an edge with the monitor's update.

// File: rtl/dac_word_rx_pkg.sv
package dac_word_rx_pkg;
    // Which transition an edge detector reports
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

    localparam int unsigned DEF_WORD_BITS   = 16;
    localparam int unsigned DEF_SAMPLE_BITS = 14;
endpackage

// File: rtl/dwr_edge_det.sv
module dwr_edge_det
    import dac_word_rx_pkg::*;
#(
    parameter edge_kind_e KIND    = EDGE_RISE,
    parameter logic       RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic pulse
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    generate
        if (KIND == EDGE_RISE) begin : g_rise
            assign pulse = sig & ~prev_q;
        end else begin : g_fall
            assign pulse = ~sig & prev_q;
        end
    endgenerate
endmodule

// File: rtl/dwr_framer.sv
module dwr_framer #(
    parameter int unsigned WORD_BITS   = 16,
    parameter int unsigned SAMPLE_BITS = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bit_tick,
    input  logic                   word_open,
    input  logic                   frame_n,
    input  logic                   sdata,
    output logic [SAMPLE_BITS-1:0] sample,
    output logic                   load,
    output logic                   frame_err
);
    localparam int unsigned CNT_W = $clog2(WORD_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_BITS);

    typedef struct packed {
        logic                   active;
        logic [CNT_W-1:0]       cnt;
        logic [WORD_BITS-1:0]   shift;
        logic [SAMPLE_BITS-1:0] sample;
        logic                   load;
        logic                   err;
    } fr_state_t;

    fr_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;

        // A new frame marker always wins; an unfinished word is dropped
        if (word_open) begin
            if (st_q.active) st_d.err = 1'b1;
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.shift  = '0;
        end

        if (bit_tick && st_d.active) begin
            if (st_d.cnt == '0 && frame_n) begin
                // marker already gone at the first bit: short pulse
                st_d.err    = 1'b1;
                st_d.active = 1'b0;
            end else begin
                st_d.shift = {st_d.shift[WORD_BITS-2:0], sdata};
                st_d.cnt   = st_d.cnt + 1'b1;
                if (st_d.cnt == LAST_CNT) begin
                    st_d.sample = st_d.shift[WORD_BITS-1 -: SAMPLE_BITS];
                    st_d.load   = 1'b1;
                    st_d.active = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample    = st_q.sample;
    assign load      = st_q.load;
    assign frame_err = st_q.err;

    // R4: strobe never lasts two cycles
    a_r4_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);
    // R4: held sample only moves together with the strobe
    a_r4_sample_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |-> $stable(sample));
    // R7: error flag is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);
    // R5: reopening an unfinished word flags an error
    a_r5_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (word_open && st_q.active) |=> frame_err);
    // R8: no strobe can follow a cycle with no open word and no opening edge
    a_r8_idle_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !word_open) |=> !load);
    // R2: bit counter never passes the word length
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_CNT);
endmodule

// File: rtl/dac_word_rx.sv
module dac_word_rx
    import dac_word_rx_pkg::*;
#(
    parameter int unsigned WORD_BITS   = DEF_WORD_BITS,
    parameter int unsigned SAMPLE_BITS = DEF_SAMPLE_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sclk,
    input  logic                   sdata,
    input  logic                   frame_n,
    output logic [SAMPLE_BITS-1:0] sample,
    output logic                   load,
    output logic                   frame_err
);
    logic bit_tick;
    logic word_open;

    dwr_edge_det #(.KIND(EDGE_RISE), .RST_VAL(1'b1)) i_sclk_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (sclk),
        .pulse (bit_tick)
    );

    dwr_edge_det #(.KIND(EDGE_FALL), .RST_VAL(1'b1)) i_frame_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (frame_n),
        .pulse (word_open)
    );

    dwr_framer #(.WORD_BITS(WORD_BITS), .SAMPLE_BITS(SAMPLE_BITS)) i_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .word_open (word_open),
        .frame_n   (frame_n),
        .sdata     (sdata),
        .sample    (sample),
        .load      (load),
        .frame_err (frame_err)
    );
endmodule

// File: tb/test_dac_word_rx.sv
module test_dac_word_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sdata = 1'b0;
    logic        frame_n = 1'b1;
    logic [13:0] sample;
    logic        load;
    logic        frame_err;

    int total = 0;
    int bad = 0;
    int loads = 0;
    logic [13:0] last_sample = '0;
    int exp_loads = 0;
    logic [13:0] exp_sample = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dac_word_rx i_dac_word_rx (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata),
        .frame_n(frame_n), .sample(sample), .load(load), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (load) begin
            loads++;
            last_sample = sample;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [13:0] top14(input logic [15:0] w);
        return w[15:2];
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; sclk = 1'b0; frame_n = 1'b1; sdata = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        loads = 0; exp_loads = 0; exp_sample = '0; last_sample = '0;
    endtask

    task automatic clk_bit(input logic b, input int hold);
        sdata = b; sclk = 1'b0;
        repeat (hold + 1) tick();
        sclk = 1'b1;
        tick();
    endtask

    task automatic send_word(input logic [15:0] w, input int hold, input bit chk);
        frame_n = 1'b0; sclk = 1'b0;
        tick();
        for (int i = 15; i >= 0; i--) begin
            clk_bit(w[i], hold);
            if (i == 0 && chk) begin
                check(load === 1'b1, "R4 strobe after 16th bit", int'(load), 1);
                check(sample === top14(w), "R2 sample value", int'(sample), int'(top14(w)));
            end
            repeat (hold) tick();
            frame_n = 1'b1;
        end
        sclk = 1'b0;
        tick();
        if (chk) check(load === 1'b0, "R4 strobe one cycle", int'(load), 0);
        exp_loads++;
        exp_sample = top14(w);
    endtask

    task automatic check_loads(input string tag);
        tick();
        check(loads == exp_loads, tag, loads, exp_loads);
        check(last_sample === exp_sample, tag, int'(last_sample), int'(exp_sample));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (2) tick();
        check(sample === 14'd0 && load === 1'b0 && frame_err === 1'b0,
              "R1 outputs during reset", int'({sample, load, frame_err}), 0);
        rst_n = 1'b1;
        tick();
        check(sample === 14'd0 && load === 1'b0 && frame_err === 1'b0,
              "R1 outputs after reset", int'({sample, load, frame_err}), 0);

        // R8: rises before any frame marker
        for (int k = 0; k < 5; k++) clk_bit(1'b1, 0);
        sclk = 1'b0; tick();
        check(loads == 0, "R8 no load without frame", loads, 0);

        send_word(16'hA5C3, 0, 1'b1);
        send_word(16'h3FFC, 0, 1'b1);
        check_loads("R2 directed words");

        // R3: words differing only in the last two bits
        send_word(16'h1230, 0, 1'b1);
        send_word(16'h1233, 0, 1'b1);
        check_loads("R3 trailing bits ignored");

        // R8: rises after the 16th bit are ignored
        for (int k = 0; k < 4; k++) clk_bit(1'b0, 0);
        sclk = 1'b0; tick();
        check_loads("R8 no load after word end");
        send_word(16'hFFFF, 1, 1'b0);
        check_loads("R8 later word unshifted");

        // R2/R4 random words with stretched timing
        for (int n = 0; n < 40; n++) begin
            logic [15:0] w;
            w = 16'($urandom);
            send_word(w, int'($urandom % 3), 1'b0);
            repeat (int'($urandom % 3)) tick();
        end
        check_loads("R2 random words");
        check(frame_err === 1'b0, "R2 no error on good words", int'(frame_err), 0);

        // R5: early marker aborts the open word
        frame_n = 1'b0; tick();
        for (int k = 0; k < 9; k++) begin
            clk_bit(1'b1, 0); frame_n = 1'b1;
        end
        sclk = 1'b0; tick();
        check(loads == exp_loads, "R5 no load before abort", loads, exp_loads);
        send_word(16'h0F0F, 0, 1'b1);
        check_loads("R5 new word after abort");
        check(frame_err === 1'b1, "R5 error set on abort", int'(frame_err), 1);

        // R7: error survives good words, cleared only by reset
        send_word(16'h5555, 0, 1'b0);
        check_loads("R7 good word with error set");
        check(frame_err === 1'b1, "R7 error sticky", int'(frame_err), 1);
        do_reset();
        check(frame_err === 1'b0, "R7 reset clears error", int'(frame_err), 0);

        // R6: marker back high before the first serial rise
        frame_n = 1'b0; tick();
        frame_n = 1'b1; tick();
        for (int k = 0; k < 16; k++) clk_bit(1'b1, 0);
        sclk = 1'b0; tick();
        check(frame_err === 1'b1, "R6 short pulse flagged", int'(frame_err), 1);
        check_loads("R6 short pulse never loaded");
        send_word(16'hC001, 0, 1'b1);
        check_loads("R6 next frame received");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule